// File: doc/BRIEF.md
# Masked Trailing-Bit Manipulation Unit

This execution unit computes one generalized trailing-bit operation on a 64-bit operand. A five-bit mode selector picks three things. The first is whether the source is inverted. The second is one of four increment, decrement or negation forms of the source. The third is the bitwise operator that merges the two terms. With these choices the single operation covers idioms such as set-before-first, set-only-first (isolate lowest set bit) and set-including-first, along with their relatives.

All work is done under a predicate mask. The mask comes from a second operand. When the instruction's mask register field was zero, the mask is all ones instead. The source is masked before any arithmetic, so carries and borrows run only through the selected bits. A preserve flag chooses what happens to source bits outside the mask: they are either copied into the result or cleared.

The unit does not decode instructions. It receives the mode and the preserve flag already extracted from the instruction word. It takes operands with a valid strobe and presents a registered result one cycle later. When the reserved operator code is used, it raises an illegal-operation flag and the result is zero.

Top module: `tbm_unit`

## Requirements
- R1: The effective mask is all ones when `msk_zero` is 1, and `msk` otherwise. The source is ANDed with the effective mask before any other step, so a mask of zero leaves no source bits in play.
- R2: `mode[0]` selects the first term. With 1 the term is the masked source. With 0 it is the bitwise inverse of the masked source.
- R3: `mode[2:1]` selects the second term, where x is the masked source: 00 gives (~x)+1, 01 gives x-1, 10 gives x+1 and 11 gives ~(x+1). Both terms are ANDed with the effective mask before they are combined.
- R4: `mode[4:3]` selects the operator: 00 is OR, 01 is AND and 10 is XOR. The combined value is ANDed with the effective mask.
- R5: `mode[4:3]` = 11 is reserved. It sets `illegal` to 1 and forces `result` to zero for that operation, whatever the operands and the preserve flag are. Every other mode clears `illegal`.
- R6: When `keep` is 1, source bits outside the effective mask are ORed into the result. When `keep` is 0, those result bits are zero.
- R7: Mode 01010 yields set-before-first, mode 01001 yields set-only-first and mode 10000 yields set-including-first. For example, a source of 0x58 with a full mask gives 0x07, 0x08 and 0x0F respectively.
- R8: All arithmetic is 64 bits wide and wraps modulo 2^64. For example, x+1 of all ones is zero and x-1 of zero is all ones.
- R9: `out_valid` equals the value `in_valid` had one cycle earlier.
- R10: `result` and `illegal` change only after a cycle in which `in_valid` was high. Otherwise they hold their values.
- R11: Synchronous active-high reset clears `out_valid`, `result` and `illegal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| src | input | 64 | Source operand |
| msk | input | 64 | Mask operand |
| msk_zero | input | 1 | Mask register field was zero; use an all-ones mask |
| mode | input | 5 | Mode selector: bit 0 first term, bits 2:1 second term, bits 4:3 operator |
| keep | input | 1 | Preserve source bits outside the mask |
| out_valid | output | 1 | Result is valid |
| result | output | 64 | Registered result |
| illegal | output | 1 | Reserved operator code was used |

## Verification
Every path in the datapath ends at the result register one cycle after the operands are accepted. Any wrong selection of term, operator or mask therefore shows up as a wrong `result` value on the next cycle. A carry chain that fails to wrap, or that runs across masked-out bits, shows up at the high end of the result or outside the mask. A corrupted valid or hold path appears within one cycle as a result or flag that changes without a strobe, or as `out_valid` drifting out of step with `in_valid`. A reserved-mode fault appears in the same cycle as a nonzero result or a missing `illegal` flag.

// File: rtl/tbm_pkg.sv
package tbm_pkg;
  typedef enum logic [1:0] {
    T2_NEG  = 2'b00,
    T2_DEC  = 2'b01,
    T2_INC  = 2'b10,
    T2_NINC = 2'b11
  } term2_e;

  typedef enum logic [1:0] {
    OP_OR   = 2'b00,
    OP_AND  = 2'b01,
    OP_XOR  = 2'b10,
    OP_RSVD = 2'b11
  } comb_op_e;

  localparam int unsigned MODE_W = 5;
endpackage

// File: rtl/tbm_mask_sel.sv
// Effective mask selection and operand gating.
module tbm_mask_sel #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] src,
  input  logic [W-1:0] msk,
  input  logic         msk_zero,
  output logic [W-1:0] mask,
  output logic [W-1:0] xm,
  output logic [W-1:0] outside
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  always_comb begin
    mask    = msk_zero ? ALL_ONES : msk;
    xm      = src & mask;
    outside = src & ~mask;
  end
endmodule

// File: rtl/tbm_terms.sv
// Builds the two masked terms from the gated source.
module tbm_terms
  import tbm_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] xm,
  input  logic [W-1:0] mask,
  input  logic         first_pos,
  input  term2_e       sel2,
  output logic [W-1:0] t1,
  output logic [W-1:0] t2
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] inc_v;
  logic [W-1:0] dec_v;
  logic [W-1:0] neg_v;
  logic [W-1:0] raw2;

  always_comb begin
    inc_v = xm + ONE;
    dec_v = xm - ONE;
    neg_v = (~xm) + ONE;
    unique case (sel2)
      T2_NEG:  raw2 = neg_v;
      T2_DEC:  raw2 = dec_v;
      T2_INC:  raw2 = inc_v;
      default: raw2 = ~inc_v;
    endcase
    t1 = (first_pos ? xm : ~xm) & mask;
    t2 = raw2 & mask;
  end
endmodule

// File: rtl/tbm_combine.sv
// Per-bit operator, output masking and preserve merge.
module tbm_combine
  import tbm_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] t1,
  input  logic [W-1:0] t2,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] outside,
  input  logic         keep,
  input  comb_op_e     op,
  output logic [W-1:0] res,
  output logic         bad
);
  logic rsvd;
  assign rsvd = (op == OP_RSVD);
  assign bad  = rsvd;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic c;
    always_comb begin
      unique case (op)
        OP_OR:   c = t1[i] | t2[i];
        OP_AND:  c = t1[i] & t2[i];
        OP_XOR:  c = t1[i] ^ t2[i];
        default: c = 1'b0;
      endcase
      res[i] = rsvd ? 1'b0 : ((c & mask[i]) | (keep & outside[i]));
    end
  end
endmodule

// File: rtl/tbm_unit.sv
// Masked trailing-bit manipulation unit, one-cycle registered.
module tbm_unit
  import tbm_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [W-1:0]      src,
  input  logic [W-1:0]      msk,
  input  logic              msk_zero,
  input  logic [MODE_W-1:0] mode,
  input  logic              keep,
  output logic              out_valid,
  output logic [W-1:0]      result,
  output logic              illegal
);
  logic [W-1:0] mask_w;
  logic [W-1:0] xm_w;
  logic [W-1:0] out_w;
  logic [W-1:0] t1_w;
  logic [W-1:0] t2_w;
  logic [W-1:0] res_w;
  logic         bad_w;

  tbm_mask_sel #(.W(W)) mask_i (
    .src      (src),
    .msk      (msk),
    .msk_zero (msk_zero),
    .mask     (mask_w),
    .xm       (xm_w),
    .outside  (out_w)
  );

  tbm_terms #(.W(W)) terms_i (
    .xm        (xm_w),
    .mask      (mask_w),
    .first_pos (mode[0]),
    .sel2      (term2_e'(mode[2:1])),
    .t1        (t1_w),
    .t2        (t2_w)
  );

  tbm_combine #(.W(W)) comb_i (
    .t1      (t1_w),
    .t2      (t2_w),
    .mask    (mask_w),
    .outside (out_w),
    .keep    (keep),
    .op      (comb_op_e'(mode[4:3])),
    .res     (res_w),
    .bad     (bad_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= res_w;
        illegal <= bad_w;
      end
    end
  end
endmodule

// File: rtl/tbm_unit_chk.sv
// Port-level properties for tbm_unit.
module tbm_unit_chk #(
  parameter int unsigned W = 64
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [W-1:0] src,
  input logic [W-1:0] msk,
  input logic         msk_zero,
  input logic [4:0]   mode,
  input logic         keep,
  input logic         out_valid,
  input logic [W-1:0] result,
  input logic         illegal
);
  logic [W-1:0] eff_mask;
  assign eff_mask = msk_zero ? {W{1'b1}} : msk;

  a_r11_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && !illegal && result == '0));

  a_r9_valid_high: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r9_valid_low: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && $stable(illegal)));

  a_r5_flag: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (illegal == ($past(mode[4:3]) == 2'b11)));

  a_r5_zero_result: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode[4:3] == 2'b11) |=> (result == '0));

  a_r6_clear_outside: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !keep) |=> ((result & ~$past(eff_mask)) == '0));

  a_r6_keep_outside: assert property (@(posedge clk) disable iff (rst)
    (in_valid && keep && mode[4:3] != 2'b11) |=>
      (((result ^ $past(src)) & ~$past(eff_mask)) == '0));
endmodule

bind tbm_unit tbm_unit_chk #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .src(src), .msk(msk),
  .msk_zero(msk_zero), .mode(mode), .keep(keep), .out_valid(out_valid),
  .result(result), .illegal(illegal)
);

// File: tb/tbm_unit_tb_top.sv
module tbm_unit_tb_top;
  localparam int W = 64;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [W-1:0] src = '0;
  logic [W-1:0] msk = '0;
  logic         msk_zero = 1'b0;
  logic [4:0]   mode = '0;
  logic         keep = 1'b0;
  logic         out_valid;
  logic [W-1:0] result;
  logic         illegal;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tbm_unit #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src(src), .msk(msk),
    .msk_zero(msk_zero), .mode(mode), .keep(keep), .out_valid(out_valid),
    .result(result), .illegal(illegal)
  );

  function automatic logic [W:0] ref_model(logic [W-1:0] s, logic [W-1:0] m,
                                           logic mz, logic [4:0] md, logic kp);
    logic [W-1:0] mk, x, a, b, r;
    mk = mz ? ONES : m;
    x  = s & mk;
    a  = md[0] ? x : ~x;
    case (md[2:1])
      2'd0: b = 64'd0 - x;
      2'd1: b = x - 64'd1;
      2'd2: b = x + 64'd1;
      default: b = ~(x + 64'd1);
    endcase
    a = a & mk;
    b = b & mk;
    case (md[4:3])
      2'd0: r = a | b;
      2'd1: r = a & b;
      2'd2: r = a ^ b;
      default: r = '0;
    endcase
    if (md[4:3] == 2'd3) return {1'b1, {W{1'b0}}};
    r = r & mk;
    if (kp) r = r | (s & ~mk);
    return {1'b0, r};
  endfunction

  task automatic chk(string tag, logic [W-1:0] got, logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // Drive one operation, then sample at the following negedge.
  task automatic run_op(logic [W-1:0] s, logic [W-1:0] m, logic mz,
                        logic [4:0] md, logic kp);
    @(negedge clk);
    src = s; msk = m; msk_zero = mz; mode = md; keep = kp; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic op_and_check(string tag, logic [W-1:0] s, logic [W-1:0] m,
                              logic mz, logic [4:0] md, logic kp);
    logic [W:0] e;
    e = ref_model(s, m, mz, md, kp);
    run_op(s, m, mz, md, kp);
    chk({tag, " result"}, result, e[W-1:0]);
    chk({tag, " illegal"}, {63'd0, illegal}, {63'd0, e[W]});
    chk({tag, " out_valid"}, {63'd0, out_valid}, 64'd1);
  endtask

  task automatic t_reset;
    chk("R11 out_valid", {63'd0, out_valid}, 64'd0);
    chk("R11 result", result, 64'd0);
    chk("R11 illegal", {63'd0, illegal}, 64'd0);
  endtask

  task automatic t_named;
    run_op(64'h58, 64'd0, 1'b1, 5'b01010, 1'b0);
    chk("R7 set-before-first", result, 64'h07);
    run_op(64'h58, 64'd0, 1'b1, 5'b01001, 1'b0);
    chk("R7 set-only-first", result, 64'h08);
    run_op(64'h58, 64'd0, 1'b1, 5'b10000, 1'b0);
    chk("R7 set-including-first", result, 64'h0F);
  endtask

  task automatic t_mask_keep;
    run_op(64'h58, 64'hF0, 1'b0, 5'b01001, 1'b0);
    chk("R1 R6 masked isolate keep=0", result, 64'h10);
    run_op(64'h58, 64'hF0, 1'b0, 5'b01001, 1'b1);
    chk("R6 masked isolate keep=1", result, 64'h18);
    run_op(64'hDEAD_BEEF_0123_4567, 64'd0, 1'b0, 5'b10000, 1'b0);
    chk("R1 zero mask keep=0", result, 64'd0);
    run_op(64'hDEAD_BEEF_0123_4567, 64'd0, 1'b0, 5'b10000, 1'b1);
    chk("R1 R6 zero mask keep=1", result, 64'hDEAD_BEEF_0123_4567);
  endtask

  task automatic t_wrap;
    run_op(ONES, 64'd0, 1'b1, 5'b10101, 1'b0);
    chk("R8 inc wraps", result, ONES);
    run_op(64'd0, 64'd0, 1'b1, 5'b00011, 1'b0);
    chk("R8 dec wraps", result, ONES);
    op_and_check("R3 zero source neg", 64'd0, 64'd0, 1'b1, 5'b10000, 1'b0);
    op_and_check("R3 ones source ninc", ONES, 64'd0, 1'b1, 5'b00110, 1'b1);
  endtask

  task automatic t_reserved;
    run_op(ONES, ONES, 1'b0, 5'b11011, 1'b1);
    chk("R5 reserved result", result, 64'd0);
    chk("R5 reserved flag", {63'd0, illegal}, 64'd1);
    run_op(64'h1234, 64'd0, 1'b1, 5'b00000, 1'b0);
    chk("R5 flag clears", {63'd0, illegal}, 64'd0);
  endtask

  task automatic t_all_modes;
    for (int md = 0; md < 32; md++) begin
      for (int k = 0; k < 4; k++) begin
        logic [W-1:0] s, m;
        s = {$urandom, $urandom};
        m = {$urandom, $urandom};
        if (k == 0) s = s & ~(s - 64'd1) ^ 64'h0;
        op_and_check($sformatf("R2 R3 R4 mode=%b k=%0d", md[4:0], k),
                     s, m, (k == 1), md[4:0], k[0]);
      end
    end
  endtask

  task automatic t_hold_valid;
    logic [W-1:0] held;
    run_op(64'hF0, 64'd0, 1'b1, 5'b01001, 1'b0);
    held = result;
    @(negedge clk);
    src = 64'h3; mode = 5'b11000;
    @(negedge clk);
    chk("R10 result holds", result, held);
    chk("R10 illegal holds", {63'd0, illegal}, 64'd0);
    chk("R9 out_valid low", {63'd0, out_valid}, 64'd0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_named();
    t_mask_keep();
    t_wrap();
    t_reserved();
    t_all_modes();
    t_hold_valid();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule